// File: doc/BRIEF.md
# Receive Timeslot Payload Replacement

This block sits on the receive byte stream of a 32-timeslot E1 frame. It rewrites each timeslot as that slot's own configuration byte directs. Every beat carries a payload byte, its timeslot number and a four-bit signaling nibble (A, B, C, D).

The configuration can substitute any of these for the payload byte:
- a programmable trunk-conditioning code byte;
- a digital milliwatt tone in µ-law or A-law;
- a byte from a 2^15−1 pseudo-random generator.

Independently of that, it can substitute a programmable signaling nibble. It can also tell a fractional clock-slave receiver to withhold the clock for the slot.

Slots marked for test either feed their bytes to an external pattern checker or receive generator output. A mode pin chooses which. The generator output is one continuous stream that runs only through the marked slots.

Three tables of 32 bytes hold the configuration, the data codes and the signaling codes. They are written and read through a small indirect port: an address, a write strobe, a read strobe and a data byte. A write is staged and only becomes active at the next frame start. A frame therefore never mixes old and new settings.

Both stream sides use valid/ready. A beat moves when valid and ready are high together at a clock edge. The output is a single register stage: `in_ready` is high whenever that stage is empty or is being drained in the same cycle. While `out_ready` is low, a held output beat keeps all its fields unchanged. The test strobe and test byte travel with the output beat they belong to.

Top module: `rpl_rx_replace`

## Requirements
- R1: An accepted input beat appears on the output one clock later. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` low, the output beat holds every field. Beats are neither lost nor repeated. `out_slot` carries the input timeslot.
- R2: The register address for slot s (0..31) selects the table as follows:
  - 0x20+s selects the configuration table;
  - 0x40+s selects the data code table;
  - 0x60+s, for s of 1 to 31, selects the signaling code table.
  
  Writes to 0x60 and to 0x00..0x1F are ignored. A read strobe returns the stored byte on `reg_rdata` on the next clock; unused addresses read as 0.
- R3: A written value is staged. It takes effect from the next accepted beat with slot 0, and that beat already uses it. Beats before that boundary use the old value.
- R4: Configuration bit 6 set replaces the payload with the slot's data code byte.
- R5: Configuration bit 4 set replaces the payload with a milliwatt tone. Bit 3 selects the law: 0 gives µ-law, 1 gives A-law.
  - The µ-law sequence is 1E 0B 0B 1E 9E 8B 8B 9E.
  - The A-law sequence is 34 21 21 34 B4 A1 A1 B4.
  
  Each slot keeps its own sequence position, which advances by one each time that slot emits a tone byte.
- R6: Configuration bit 5 set on slots 1..31 replaces `out_sig` with bits 3..0 of the slot's signaling code. On slot 0 the bit has no effect.
- R7: Configuration bit 7 set with `pat_gen_mode` high replaces the payload with the next generator byte.
  - The generator is a 15-bit register, seeded with all ones at reset.
  - Each step shifts in `s[14]^s[13]` at bit 0, and that new bit is the output bit.
  - A byte takes eight steps, the first into bit 7.
  - The register advances only on such beats.
- R8: Configuration bit 7 set with `pat_gen_mode` low raises `test_valid` with the output beat. `test_byte` then carries the unmodified input payload, and the payload itself is not replaced by the generator.
- R9: When several payload replacements are enabled, the order of precedence is generator, then tone, then data code, then pass-through. A tone advances its sequence only when it is emitted.
- R10: `out_clk_en` is low for a beat exactly when `frac_clk_mode` was high and configuration bit 6 was set at acceptance. It is high otherwise.
- R11: After reset all tables are zero and every beat passes through unchanged. After reset `out_valid` and `reg_rdata` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_gen_mode | input | 1 | 1: test slots get generator bytes; 0: test slots are extracted |
| frac_clk_mode | input | 1 | Fractional clock-slave mode enable |
| reg_wr | input | 1 | Indirect table write strobe |
| reg_rd | input | 1 | Indirect table read strobe |
| reg_addr | input | 7 | Indirect table address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_rd` |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with `in_valid` |
| in_data | input | 8 | Received payload byte |
| in_slot | input | 5 | Timeslot number of the beat |
| in_sig | input | 4 | Received ABCD signaling nibble |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_data | output | 8 | Payload after replacement |
| out_slot | output | 5 | Timeslot number of the output beat |
| out_sig | output | 4 | Signaling nibble after replacement |
| out_clk_en | output | 1 | Receive clock enable for this slot |
| test_valid | output | 1 | Extracted test byte present with this beat |
| test_byte | output | 8 | Unmodified payload for the pattern checker |

## Verification
Two kinds of event can meet at one clock edge: a table write, and the acceptance of a slot-0 beat that commits staged values. Random writes are spread across the frame while random stalls shift the acceptance edges, so writes do land on the very edge of a frame start.

The bench model mirrors the design's order: the boundary commit takes the staged tables as they stood before that edge, and the write then lands in staging. Each output beat is compared with that model, so a write that leaks in early or late shows up as a wrong byte.

A second overlap arises when one configuration byte enables generator, tone and data code together. There the bench checks precedence, and checks that the tone position and the generator state advance only when their source actually wins.

// File: rtl/rpl_pkg.sv
package rpl_pkg;

  // configuration byte field positions
  localparam int CFG_TEST  = 7;
  localparam int CFG_TRUNK = 6;
  localparam int CFG_SIGSUB = 5;
  localparam int CFG_TONE  = 4;
  localparam int CFG_ALAW  = 3;

  // table select = top two address bits
  localparam logic [1:0] TBL_CFG  = 2'b01;
  localparam logic [1:0] TBL_DATA = 2'b10;
  localparam logic [1:0] TBL_SIG  = 2'b11;

  localparam logic [14:0] PRBS_SEED = 15'h7FFF;

  typedef enum logic [1:0] {
    SRC_PASS,
    SRC_TRUNK,
    SRC_TONE,
    SRC_PRBS
  } src_e;

  typedef struct packed {
    logic [14:0] state;
    logic [7:0]  bits;
  } prbs_step_t;

  // milliwatt tone: outer/inner magnitude, sign flips in the second half
  function automatic logic [7:0] tone_byte(input logic alaw, input logic [2:0] pos);
    logic       inner;
    logic [7:0] mag;
    inner = pos[0] ^ pos[1];
    if (alaw) mag = inner ? 8'h21 : 8'h34;
    else      mag = inner ? 8'h0B : 8'h1E;
    return {pos[2] | mag[7], mag[6:0]};
  endfunction

  // eight steps of x^15+x^14+1, first bit into bit 7
  function automatic prbs_step_t prbs_step8(input logic [14:0] s);
    prbs_step_t r;
    logic [14:0] t;
    logic        nb;
    t = s;
    r.bits = '0;
    for (int i = 0; i < 8; i++) begin
      nb = t[14] ^ t[13];
      t  = {t[13:0], nb};
      r.bits[7-i] = nb;
    end
    r.state = t;
    return r;
  endfunction

endpackage

// File: rtl/rpl_tables.sv
module rpl_tables
  import rpl_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic [SLOT_W+1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              frame_load,
  input  logic [SLOT_W-1:0] slot,
  output logic [7:3]        cfg,
  output logic [7:0]        dcode,
  output logic [3:0]        scode
);
  localparam int NSLOT = 1 << SLOT_W;
  localparam int AW    = SLOT_W + 2;

  logic [7:0] stg_cfg [NSLOT];
  logic [7:0] stg_dat [NSLOT];
  logic [7:0] stg_sig [NSLOT];
  logic [7:0] act_cfg [NSLOT];
  logic [7:0] act_dat [NSLOT];
  logic [7:0] act_sig [NSLOT];

  logic [1:0]        tsel;
  logic [SLOT_W-1:0] aslot;
  logic              sig_hole;
  assign tsel     = addr[AW-1:AW-2];
  assign aslot    = addr[SLOT_W-1:0];
  assign sig_hole = (aslot == '0);

  // staged copy: written by the register port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        stg_cfg[i] <= '0;
        stg_dat[i] <= '0;
        stg_sig[i] <= '0;
      end
    end else if (wr) begin
      case (tsel)
        TBL_CFG:  stg_cfg[aslot] <= wdata;
        TBL_DATA: stg_dat[aslot] <= wdata;
        TBL_SIG:  if (!sig_hole) stg_sig[aslot] <= wdata;
        default:  ;
      endcase
    end
  end

  // active copy: committed at the frame start
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) begin
        act_cfg[i] <= '0;
        act_dat[i] <= '0;
        act_sig[i] <= '0;
      end
    end else if (frame_load) begin
      for (int i = 0; i < NSLOT; i++) begin
        act_cfg[i] <= stg_cfg[i];
        act_dat[i] <= stg_dat[i];
        act_sig[i] <= stg_sig[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      case (tsel)
        TBL_CFG:  rdata <= stg_cfg[aslot];
        TBL_DATA: rdata <= stg_dat[aslot];
        TBL_SIG:  rdata <= sig_hole ? 8'h00 : stg_sig[aslot];
        default:  rdata <= 8'h00;
      endcase
    end
  end

  // the frame-start beat already sees the staged values
  logic [7:0] cfg_full;
  logic [7:0] sig_full;
  always_comb begin
    if (frame_load) begin
      cfg_full = stg_cfg[slot];
      dcode    = stg_dat[slot];
      sig_full = stg_sig[slot];
    end else begin
      cfg_full = act_cfg[slot];
      dcode    = act_dat[slot];
      sig_full = act_sig[slot];
    end
  end

  assign cfg   = cfg_full[7:3];
  assign scode = sig_full[3:0];

  logic unused_bits;
  assign unused_bits = ^{cfg_full[2:0], sig_full[7:4]};

endmodule

// File: rtl/rpl_prbs.sv
module rpl_prbs
  import rpl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  output logic [7:0] byte_o
);
  logic [14:0] state;
  prbs_step_t  nxt;

  assign nxt    = prbs_step8(state);
  assign byte_o = nxt.bits;

  always_ff @(posedge clk) begin
    if (!rst_n)   state <= PRBS_SEED;
    else if (adv) state <= nxt.state;
  end
endmodule

// File: rtl/rpl_tone_pos.sv
module rpl_tone_pos #(
  parameter int SLOT_W = 5,
  parameter int POS_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot,
  input  logic              adv,
  output logic [POS_W-1:0]  pos
);
  localparam int NSLOT = 1 << SLOT_W;

  logic [POS_W-1:0] pos_q [NSLOT];

  assign pos = pos_q[slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOT; i++) pos_q[i] <= '0;
    end else if (adv) begin
      pos_q[slot] <= pos_q[slot] + 1'b1;
    end
  end
endmodule

// File: rtl/rpl_rx_replace.sv
module rpl_rx_replace
  import rpl_pkg::*;
#(
  parameter int SLOT_W = 5,
  localparam int ADDR_W = SLOT_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pat_gen_mode,
  input  logic              frac_clk_mode,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic [SLOT_W-1:0] in_slot,
  input  logic [3:0]        in_sig,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic [SLOT_W-1:0] out_slot,
  output logic [3:0]        out_sig,
  output logic              out_clk_en,
  output logic              test_valid,
  output logic [7:0]        test_byte
);
  logic       in_fire;
  logic       frame_load;
  logic [7:3] cfg;
  logic [7:0] dcode;
  logic [3:0] scode;
  logic [7:0] prbs_byte;
  logic [2:0] tone_pos;
  src_e       src;
  logic [7:0] data_nxt;
  logic [3:0] sig_nxt;
  logic       extract;

  logic              v_q;
  logic [7:0]        d_q;
  logic [SLOT_W-1:0] s_q;
  logic [3:0]        g_q;
  logic              ce_q;
  logic              tv_q;
  logic [7:0]        tb_q;

  assign in_ready   = !v_q || out_ready;
  assign in_fire    = in_valid && in_ready;
  assign frame_load = in_fire && (in_slot == '0);

  rpl_tables #(.SLOT_W(SLOT_W)) u_tables (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .rd         (reg_rd),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .frame_load (frame_load),
    .slot       (in_slot),
    .cfg        (cfg),
    .dcode      (dcode),
    .scode      (scode)
  );

  rpl_prbs u_prbs (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (in_fire && src == SRC_PRBS),
    .byte_o (prbs_byte)
  );

  rpl_tone_pos #(.SLOT_W(SLOT_W), .POS_W(3)) u_tone (
    .clk   (clk),
    .rst_n (rst_n),
    .slot  (in_slot),
    .adv   (in_fire && src == SRC_TONE),
    .pos   (tone_pos)
  );

  // payload source in order of precedence
  always_comb begin
    if (cfg[CFG_TEST] && pat_gen_mode) src = SRC_PRBS;
    else if (cfg[CFG_TONE])            src = SRC_TONE;
    else if (cfg[CFG_TRUNK])           src = SRC_TRUNK;
    else                               src = SRC_PASS;
  end

  always_comb begin
    case (src)
      SRC_PRBS:  data_nxt = prbs_byte;
      SRC_TONE:  data_nxt = tone_byte(cfg[CFG_ALAW], tone_pos);
      SRC_TRUNK: data_nxt = dcode;
      default:   data_nxt = in_data;
    endcase
  end

  assign sig_nxt = (cfg[CFG_SIGSUB] && in_slot != '0) ? scode : in_sig;
  assign extract = cfg[CFG_TEST] && !pat_gen_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= 1'b0;
      d_q  <= '0;
      s_q  <= '0;
      g_q  <= '0;
      ce_q <= 1'b1;
      tv_q <= 1'b0;
      tb_q <= '0;
    end else if (in_fire) begin
      v_q  <= 1'b1;
      d_q  <= data_nxt;
      s_q  <= in_slot;
      g_q  <= sig_nxt;
      ce_q <= !(frac_clk_mode && cfg[CFG_TRUNK]);
      tv_q <= extract;
      tb_q <= in_data;
    end else if (out_ready) begin
      v_q  <= 1'b0;
      tv_q <= 1'b0;
    end
  end

  assign out_valid  = v_q;
  assign out_data   = d_q;
  assign out_slot   = s_q;
  assign out_sig    = g_q;
  assign out_clk_en = ce_q;
  assign test_valid = tv_q;
  assign test_byte  = tb_q;

endmodule

// File: rtl/rpl_rx_replace_chk.sv
module rpl_rx_replace_chk #(
  parameter int SLOT_W = 5,
  localparam int ADDR_W = SLOT_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pat_gen_mode,
  input logic              frac_clk_mode,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic [7:0]        reg_rdata,
  input logic              in_valid,
  input logic              in_ready,
  input logic [7:0]        in_data,
  input logic [SLOT_W-1:0] in_slot,
  input logic [3:0]        in_sig,
  input logic              out_valid,
  input logic              out_ready,
  input logic [7:0]        out_data,
  input logic [SLOT_W-1:0] out_slot,
  input logic [3:0]        out_sig,
  input logic              out_clk_en,
  input logic              test_valid,
  input logic [7:0]        test_byte
);
  a_r1_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_slot)
                                && $stable(out_sig) && $stable(out_clk_en));

  a_r1_beat_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  a_r1_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r8_strobe_rides_beat: assert property (@(posedge clk) disable iff (!rst_n)
    test_valid |-> out_valid);

  a_r8_extract_stall_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
    test_valid && !out_ready |=> test_valid && $stable(test_byte));

  a_r2_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd && (reg_addr == 7'h60 || reg_addr[6:5] == 2'b00) |=> reg_rdata == 8'h00);

  logic unused_ok;
  assign unused_ok = ^{pat_gen_mode, frac_clk_mode, reg_wr, reg_wdata, in_data,
                       in_slot, in_sig};
endmodule

bind rpl_rx_replace rpl_rx_replace_chk #(.SLOT_W(SLOT_W)) u_chk (.*);

// File: tb/test_rpl_rx_replace.sv
module test_rpl_rx_replace;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pat_gen_mode, frac_clk_mode;
  logic       reg_wr, reg_rd;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       in_valid, in_ready;
  logic [7:0] in_data;
  logic [4:0] in_slot;
  logic [3:0] in_sig;
  logic       out_valid, out_ready;
  logic [7:0] out_data;
  logic [4:0] out_slot;
  logic [3:0] out_sig;
  logic       out_clk_en, test_valid;
  logic [7:0] test_byte;

  always #(CLK_PERIOD/2) clk = ~clk;

  rpl_rx_replace i_rpl_rx_replace (.*);

  int total = 0;
  int bad = 0;
  bit finished = 0;
  string phase = "";

  // independent model state
  logic [7:0]  m_scfg [32], m_sdat [32], m_ssig [32];
  logic [7:0]  m_acfg [32], m_adat [32], m_asig [32];
  int          m_tone [32];
  logic [14:0] m_lfsr;

  // expected-beat ring
  logic [7:0] e_data [8];
  logic [4:0] e_slot [8];
  logic [3:0] e_sig [8];
  logic       e_ce [8], e_tv [8];
  logic [7:0] e_tb [8];
  string      e_tag [8];
  int wp = 0, rp = 0;

  logic [4:0] cur_slot = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, phase, act, exp);
    end
  endtask

  function automatic logic [7:0] tone_exp(input bit alaw, input int pos);
    logic [7:0] mu [8] = '{8'h1E, 8'h0B, 8'h0B, 8'h1E, 8'h9E, 8'h8B, 8'h8B, 8'h9E};
    logic [7:0] al [8] = '{8'h34, 8'h21, 8'h21, 8'h34, 8'hB4, 8'hA1, 8'hA1, 8'hB4};
    return alaw ? al[pos % 8] : mu[pos % 8];
  endfunction

  task automatic model_beat(input logic [4:0] s, input logic [7:0] d, input logic [3:0] g);
    logic [7:0] c, b;
    logic       nb;
    int         n;
    if (s == 0) begin
      for (int i = 0; i < 32; i++) begin
        m_acfg[i] = m_scfg[i]; m_adat[i] = m_sdat[i]; m_asig[i] = m_ssig[i];
      end
    end
    c = m_acfg[s];
    n = int'(c[7]) + int'(c[4]) + int'(c[6]);
    if (c[7] && pat_gen_mode) begin
      for (int i = 0; i < 8; i++) begin
        nb = m_lfsr[14] ^ m_lfsr[13];
        m_lfsr = {m_lfsr[13:0], nb};
        b[7-i] = nb;
      end
      e_tag[wp] = "R7";
    end else if (c[4]) begin
      b = tone_exp(c[3], m_tone[s]);
      m_tone[s]++;
      e_tag[wp] = "R5";
    end else if (c[6]) begin
      b = m_adat[s];
      e_tag[wp] = "R4";
    end else begin
      b = d;
      e_tag[wp] = "R11";
    end
    if (n > 1) e_tag[wp] = "R9";
    e_data[wp] = b;
    e_slot[wp] = s;
    e_sig[wp]  = (c[5] && s != 0) ? m_asig[s][3:0] : g;
    e_ce[wp]   = !(frac_clk_mode && c[6]);
    e_tv[wp]   = c[7] && !pat_gen_mode;
    e_tb[wp]   = d;
    wp = (wp + 1) % 8;
  endtask

  task automatic model_write(input logic [6:0] a, input logic [7:0] v);
    case (a[6:5])
      2'b01: m_scfg[a[4:0]] = v;
      2'b10: m_sdat[a[4:0]] = v;
      2'b11: if (a[4:0] != 0) m_ssig[a[4:0]] = v;
      default: ;
    endcase
  endtask

  // inputs were set just after a falling edge; judge, then move to next falling edge
  task automatic tick();
    bit inf, outf;
    #1;
    inf  = in_valid && in_ready;
    outf = out_valid && out_ready;
    if (outf) begin
      if (rp == wp) chk(0, "R1", 1, 0);
      else begin
        chk(out_data == e_data[rp], e_tag[rp], out_data, e_data[rp]);
        chk(out_slot == e_slot[rp], "R1", out_slot, e_slot[rp]);
        chk(out_sig == e_sig[rp], "R6", out_sig, e_sig[rp]);
        chk(out_clk_en == e_ce[rp], "R10", out_clk_en, e_ce[rp]);
        chk(test_valid == e_tv[rp], "R8", test_valid, e_tv[rp]);
        if (e_tv[rp]) chk(test_byte == e_tb[rp], "R8", test_byte, e_tb[rp]);
        rp = (rp + 1) % 8;
      end
    end
    if (inf) begin
      model_beat(in_slot, in_data, in_sig);
      cur_slot = cur_slot + 1;
    end
    if (reg_wr) model_write(reg_addr, reg_wdata);
    @(negedge clk);
    reg_wr = 0;
    reg_rd = 0;
  endtask

  // one beat, waiting for acceptance; out_ready random when stall set
  task automatic send(input bit stall);
    bit done;
    done = 0;
    while (!done) begin
      in_valid  = stall ? ($urandom % 5 != 0) : 1'b1;
      in_data   = 8'($urandom);
      in_slot   = cur_slot;
      in_sig    = 4'($urandom);
      out_ready = stall ? ($urandom % 4 != 0) : 1'b1;
      done      = in_valid && in_ready;
      tick();
    end
    in_valid = 0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] v);
    reg_wr = 1; reg_addr = a; reg_wdata = v;
    in_valid = 0; out_ready = 1;
    tick();
  endtask

  task automatic rd_chk(input logic [6:0] a, input logic [7:0] exp);
    reg_rd = 1; reg_addr = a;
    in_valid = 0; out_ready = 1;
    tick();
    chk(reg_rdata == exp, "R2", reg_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL R1 watchdog actual=%0h expected=%0h", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_2024));
    for (int i = 0; i < 32; i++) begin
      m_scfg[i] = 0; m_sdat[i] = 0; m_ssig[i] = 0;
      m_acfg[i] = 0; m_adat[i] = 0; m_asig[i] = 0; m_tone[i] = 0;
    end
    m_lfsr = 15'h7FFF;
    rst_n = 0; pat_gen_mode = 0; frac_clk_mode = 0;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    in_valid = 0; in_data = 0; in_slot = 0; in_sig = 0; out_ready = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    #1;
    phase = "reset";
    chk(out_valid == 0, "R11", out_valid, 0);
    chk(in_ready == 1, "R11", in_ready, 1);
    chk(reg_rdata == 0, "R11", reg_rdata, 0);
    @(negedge clk);

    // R11: untouched tables pass every beat through
    phase = "passthru";
    for (int i = 0; i < 32; i++) send(0);

    // R2: map, holes and read latency
    phase = "map";
    wr(7'h60, 8'hFF);
    wr(7'h05, 8'hAA);
    wr(7'h45, 8'h5C);
    wr(7'h25, 8'h6B);
    wr(7'h7F, 8'hC9);
    rd_chk(7'h60, 8'h00);
    rd_chk(7'h05, 8'h00);
    rd_chk(7'h45, 8'h5C);
    rd_chk(7'h25, 8'h6B);
    rd_chk(7'h7F, 8'hC9);

    // R3: a mid-frame write waits for the next slot 0
    phase = "R3 boundary";
    for (int i = 0; i < 10; i++) send(0);
    wr(7'h34, 8'h40);
    wr(7'h54, 8'h77);
    for (int i = 0; i < 22 + 32; i++) send(1);

    // R9: all three replacements on one slot, both generator modes
    phase = "R9 overlap";
    wr(7'h27, 8'hD8);
    wr(7'h47, 8'h3C);
    for (int f = 0; f < 4; f++) begin
      pat_gen_mode = f[0];
      frac_clk_mode = f[1];
      for (int i = 0; i < 32; i++) send(1);
    end

    // random mixture
    phase = "random";
    for (int n = 0; n < 4000; n++) begin
      if (n % 150 == 0) begin
        pat_gen_mode  = $urandom % 2;
        frac_clk_mode = $urandom % 2;
      end
      if ($urandom % 6 == 0) begin
        reg_wr    = 1;
        reg_addr  = {2'($urandom % 3 + 1), 5'($urandom)};
        reg_wdata = 8'($urandom);
      end
      send(1);
    end

    // drain
    phase = "drain";
    out_ready = 1; in_valid = 0;
    repeat (3) tick();
    chk(rp == wp, "R1", rp, wp);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule